// File: doc/BRIEF.md
# Write-Back Sub-Operation Scheduler

This block schedules the security work that a persistent-memory write-back needs before the write can be committed. The work is split into four stand-in sub-operations: deriving a counter from the line address, turning that counter into a pad, combining the pad with the write data into ciphertext, and computing an authentication tag over the data. Each sub-operation starts as soon as its own inputs are present. Work that depends only on the address runs alongside work that depends only on the data, so nothing waits behind a fixed serial chain.

A request opens with a one-cycle `req_go` and a kind. The kind says which inputs the caller will supply: the address alone, the data alone, or both. The address and the data each arrive with their own valid strobe. A strobe may come in the same cycle as `req_go` or in any later cycle. The real cipher and MAC are replaced by simple fixed-latency functions, so the scheduling can be checked cycle by cycle. `done` pulses once when every result the request needs is ready. The results then hold until the next request.

Top module: `wb_subop_sched`

## Requirements
- R1: While reset is held and after it is released, `done` is low and `res_pad`, `res_cipher` and `res_mac` are zero until a request produces them.
- R2: The address is captured at the first clock edge on which `addr_vld` is high, with `req_go` also high or after it. The counter unit launches on the next edge and is ready LAT_CTR edges later with counter = zero-extended address + CTR_SALT. The pad unit launches on the edge after that and is ready LAT_ENC edges later with pad = (counter rotated left by one bit) XOR PAD_KEY. The pad appears on `res_pad`.
- R3: The tag unit launches on the edge after the data is captured, whether or not any address has arrived. It is ready LAT_MAC edges later with tag = ((data XOR data-with-halves-swapped) + MAC_KEY), shown on `res_mac`.
- R4: The combine unit launches on the edge after both the pad is ready and the data is captured, whichever comes later. It is ready LAT_CMB edges later with `res_cipher` = pad XOR data.
- R5: Kind encoding on `req_kind`: 2'b01 is address-only (counter and pad), 2'b10 is data-only (tag), 2'b11 is both (all four units), and 2'b00 asks for no work. A strobe for an input that the kind does not use is ignored, and the results of units the kind does not need stay zero.
- R6: `done` is a single-cycle pulse on the edge after the last needed unit becomes ready. A kind of 2'b00 completes on the edge after `req_go`. Exactly one pulse is given per request.
- R7: Once a request has completed, all three results stay unchanged until the next `req_go`. A second strobe for an input that was already captured in the same request has no effect.
- R8: A `req_go` that arrives while a request is still in flight drops that request. It clears all results and all unit progress, and only the new request gives a `done`.
- R9: When both inputs arrive together with `req_go`, the tag work overlaps the address chain. With the default latencies `done` comes 11 edges after `req_go`, which is below the serial sum of 13 unit latencies plus hand-offs.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_go | input | 1 | Opens a new request (one cycle) |
| req_kind | input | 2 | Request kind: 01 address, 10 data, 11 both, 00 none |
| addr_vld | input | 1 | Write address valid strobe |
| addr | input | AW | Write line address |
| data_vld | input | 1 | Write data valid strobe |
| data | input | DW | Write data |
| done | output | 1 | One-cycle completion pulse |
| res_pad | output | DW | Pad result |
| res_cipher | output | DW | Ciphertext result |
| res_mac | output | DW | Tag result |

## Verification
The scheduler is driven with arrival patterns that separate its behaviours:
- Address and data arriving together with the opening strobe measure the overlap against the serial chain.
- Data arriving early, with the address late, show that the tag does not wait for the address.
- Data arriving well after the pad is ready show that the combine step waits for the later of its two inputs.
- Address-only, data-only and empty kinds, each fed the strobe they should ignore, show that unneeded units stay idle and their results stay zero.
- Directed runs add a duplicate address strobe and a restart while a request is in flight.
  - The duplicate strobe tells first-capture from last-capture.
  - The restart tells a clean drop from leftover work that would raise a second `done`.

// File: rtl/scheduler_pkg.sv
package scheduler_pkg;

   typedef enum logic [1:0] {
      RK_NONE = 2'b00,
      RK_ADDR = 2'b01,
      RK_DATA = 2'b10,
      RK_BOTH = 2'b11
   } req_kind_e;

   typedef enum logic [1:0] {
      SO_CTR = 2'b00,
      SO_ENC = 2'b01,
      SO_CMB = 2'b10,
      SO_MAC = 2'b11
   } subop_e;

   localparam int NUM_UNITS = 4;

endpackage

// File: rtl/operand_latch.sv
module operand_latch #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         vld,
   input  logic [W-1:0] din,
   output logic         have,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("operand_latch: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have <= 1'b0;
         q    <= '0;
      end else if (clr) begin
         have <= vld & en;
         q    <= (vld & en) ? din : '0;
      end else if (!have && vld && en) begin
         have <= 1'b1;
         q    <= din;
      end
   end

endmodule

// File: rtl/subop_unit.sv
module subop_unit
   import scheduler_pkg::*;
#(
   parameter int              DW  = 32,
   parameter int              LAT = 1,
   parameter subop_e          OP  = SO_CTR,
   parameter logic [DW-1:0]   KEY = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          start,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic          idle,
   output logic          rdy,
   output logic [DW-1:0] res
);

   localparam int CW = $clog2(LAT + 1);
   localparam int HW = DW / 2;

   logic [CW-1:0] cnt;
   logic [DW-1:0] op_a;
   logic [DW-1:0] op_b;
   logic [DW-1:0] f;

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("subop_unit: LAT must be at least 1");
      end
      if ((DW % 2) != 0 || DW < 2) begin : g_bad_dw
         $error("subop_unit: DW must be even and at least 2");
      end

      if (OP == SO_CTR) begin : g_ctr
         assign f = (op_a + KEY) ^ op_b;
      end else if (OP == SO_ENC) begin : g_enc
         assign f = {op_a[DW-2:0], op_a[DW-1]} ^ KEY ^ op_b;
      end else if (OP == SO_CMB) begin : g_cmb
         assign f = op_a ^ op_b ^ KEY;
      end else begin : g_mac
         assign f = ((op_a ^ {op_a[HW-1:0], op_a[DW-1:HW]}) + KEY) ^ op_b;
      end
   endgenerate

   assign idle = (cnt == '0) && !rdy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         rdy  <= 1'b0;
         res  <= '0;
         op_a <= '0;
         op_b <= '0;
      end else if (clr) begin
         cnt  <= '0;
         rdy  <= 1'b0;
         res  <= '0;
      end else if (start && idle) begin
         cnt  <= CW'(LAT);
         op_a <= a;
         op_b <= b;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
         if (cnt == CW'(1)) begin
            rdy <= 1'b1;
            res <= f;
         end
      end
   end

   // R6: a ready result stays ready until the request is cleared
   a_r6_rdy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy && !clr) |=> (rdy && $stable(res)));

   // R8: a clear wipes the unit
   a_r8_clear_wipes: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!rdy && res == '0));

endmodule

// File: rtl/wb_subop_sched.sv
module wb_subop_sched
   import scheduler_pkg::*;
#(
   parameter int            AW       = 16,
   parameter int            DW       = 32,
   parameter int            LAT_CTR  = 2,
   parameter int            LAT_ENC  = 4,
   parameter int            LAT_CMB  = 1,
   parameter int            LAT_MAC  = 6,
   parameter logic [DW-1:0] CTR_SALT = 32'h0000_1000,
   parameter logic [DW-1:0] PAD_KEY  = 32'hA5C3_0F96,
   parameter logic [DW-1:0] MAC_KEY  = 32'h1357_9BDF
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_go,
   input  logic [1:0]    req_kind,
   input  logic          addr_vld,
   input  logic [AW-1:0] addr,
   input  logic          data_vld,
   input  logic [DW-1:0] data,
   output logic          done,
   output logic [DW-1:0] res_pad,
   output logic [DW-1:0] res_cipher,
   output logic [DW-1:0] res_mac
);

   generate
      if (AW > DW) begin : g_bad_aw
         $error("wb_subop_sched: AW must not exceed DW");
      end
   endgenerate

   logic [1:0]    kind_q;
   logic          done_sent;
   logic          use_addr, use_data;
   logic          adr_have, dat_have;
   logic [AW-1:0] adr_q;
   logic [DW-1:0] dat_q;
   logic [DW-1:0] ctr_res, enc_res, cmb_res, mac_res;
   logic          ctr_rdy, enc_rdy, cmb_rdy, mac_rdy;
   logic          ctr_idle, enc_idle, cmb_idle, mac_idle;
   logic          ctr_go, enc_go, cmb_go, mac_go;
   logic          need_met;

   assign use_addr = req_go ? req_kind[0] : kind_q[0];
   assign use_data = req_go ? req_kind[1] : kind_q[1];

   operand_latch #(.W(AW)) u_adr (
      .clk(clk), .rst_n(rst_n), .clr(req_go), .en(use_addr),
      .vld(addr_vld), .din(addr), .have(adr_have), .q(adr_q)
   );

   operand_latch #(.W(DW)) u_dat (
      .clk(clk), .rst_n(rst_n), .clr(req_go), .en(use_data),
      .vld(data_vld), .din(data), .have(dat_have), .q(dat_q)
   );

   // launch each unit once its own operands are present
   assign ctr_go = !req_go && adr_have && ctr_idle;
   assign enc_go = !req_go && ctr_rdy && enc_idle;
   assign cmb_go = !req_go && (kind_q == RK_BOTH) && enc_rdy && dat_have && cmb_idle;
   assign mac_go = !req_go && dat_have && mac_idle;

   subop_unit #(.DW(DW), .LAT(LAT_CTR), .OP(SO_CTR), .KEY(CTR_SALT)) u_ctr (
      .clk(clk), .rst_n(rst_n), .clr(req_go), .start(ctr_go),
      .a(DW'(adr_q)), .b('0), .idle(ctr_idle), .rdy(ctr_rdy), .res(ctr_res)
   );

   subop_unit #(.DW(DW), .LAT(LAT_ENC), .OP(SO_ENC), .KEY(PAD_KEY)) u_enc (
      .clk(clk), .rst_n(rst_n), .clr(req_go), .start(enc_go),
      .a(ctr_res), .b('0), .idle(enc_idle), .rdy(enc_rdy), .res(enc_res)
   );

   subop_unit #(.DW(DW), .LAT(LAT_CMB), .OP(SO_CMB), .KEY('0)) u_cmb (
      .clk(clk), .rst_n(rst_n), .clr(req_go), .start(cmb_go),
      .a(enc_res), .b(dat_q), .idle(cmb_idle), .rdy(cmb_rdy), .res(cmb_res)
   );

   subop_unit #(.DW(DW), .LAT(LAT_MAC), .OP(SO_MAC), .KEY(MAC_KEY)) u_mac (
      .clk(clk), .rst_n(rst_n), .clr(req_go), .start(mac_go),
      .a(dat_q), .b('0), .idle(mac_idle), .rdy(mac_rdy), .res(mac_res)
   );

   assign need_met = (!kind_q[0] || enc_rdy) &&
                     (!kind_q[1] || mac_rdy) &&
                     ((kind_q != RK_BOTH) || cmb_rdy);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q    <= RK_NONE;
         done_sent <= 1'b1;
         done      <= 1'b0;
      end else if (req_go) begin
         kind_q    <= req_kind;
         done_sent <= 1'b0;
         done      <= 1'b0;
      end else begin
         done      <= need_met && !done_sent;
         done_sent <= done_sent || need_met;
      end
   end

   assign res_pad    = enc_res;
   assign res_cipher = cmb_res;
   assign res_mac    = mac_res;

   // R2: the pad only becomes ready after the counter
   a_r2_pad_after_ctr: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enc_rdy) |-> ctr_rdy);

   // R3: the tag only becomes ready with data captured
   a_r3_mac_has_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mac_rdy) |-> dat_have);

   // R4: the combine result needs both pad and data
   a_r4_cmb_after_deps: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmb_rdy) |-> (enc_rdy && dat_have));

   // R5: the address chain runs only for kinds that use the address
   a_r5_ctr_kind: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_rdy |-> kind_q[0]);

   // R6: done is a single-cycle pulse
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: results hold after completion until a new request
   a_r7_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (done_sent && !req_go) |=> ($stable(res_pad) && $stable(res_cipher) && $stable(res_mac)));

endmodule

// File: tb/sim_wb_subop_sched.sv
`timescale 1ns/1ps
module sim_wb_subop_sched;

   localparam int AW = 16;
   localparam int DW = 32;
   localparam int LC = 2;
   localparam int LE = 4;
   localparam int LX = 1;
   localparam int LM = 6;
   localparam logic [DW-1:0] SALT = 32'h0000_1000;
   localparam logic [DW-1:0] PKEY = 32'hA5C3_0F96;
   localparam logic [DW-1:0] MKEY = 32'h1357_9BDF;
   localparam int RUN = 40;

   localparam int NV = 7;
   localparam int            V_KIND [NV] = '{3, 3, 3, 1, 2, 0, 3};
   localparam int            V_AD   [NV] = '{0, 5, 0, 2, 0, 0, 7};
   localparam int            V_DD   [NV] = '{0, 0, 12, 1, 3, 0, 7};
   localparam logic [AW-1:0] V_ADDR [NV] = '{16'h1234, 16'hBEEF, 16'h0001, 16'hFFFF, 16'h4321, 16'h5555, 16'h8000};
   localparam logic [DW-1:0] V_DATA [NV] = '{32'hDEADBEEF, 32'h01234567, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'h80000001, 32'h12345678, 32'h00000000};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_go = 1'b0;
   logic [1:0]    req_kind = 2'b00;
   logic          addr_vld = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          data_vld = 1'b0;
   logic [DW-1:0] data = '0;
   logic          done;
   logic [DW-1:0] res_pad, res_cipher, res_mac;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   wb_subop_sched #(
      .AW(AW), .DW(DW), .LAT_CTR(LC), .LAT_ENC(LE), .LAT_CMB(LX), .LAT_MAC(LM),
      .CTR_SALT(SALT), .PAD_KEY(PKEY), .MAC_KEY(MKEY)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_go(req_go), .req_kind(req_kind),
      .addr_vld(addr_vld), .addr(addr), .data_vld(data_vld), .data(data),
      .done(done), .res_pad(res_pad), .res_cipher(res_cipher), .res_mac(res_mac)
   );

   function automatic logic [DW-1:0] f_pad(input logic [AW-1:0] a);
      logic [DW-1:0] c;
      c = DW'(a) + SALT;
      return {c[DW-2:0], c[DW-1]} ^ PKEY;
   endfunction

   function automatic logic [DW-1:0] f_mac(input logic [DW-1:0] d);
      return (d ^ {d[DW/2-1:0], d[DW-1:DW/2]}) + MKEY;
   endfunction

   function automatic int imax(input int x, input int y);
      return (x > y) ? x : y;
   endfunction

   function automatic int exp_done(input int kind, input int ad, input int dd);
      int ctr_r, enc_r, mac_r, cmb_r;
      if (kind == 0) return 1;
      ctr_r = ad + 1 + LC;
      enc_r = ctr_r + 1 + LE;
      mac_r = dd + 1 + LM;
      cmb_r = imax(enc_r, dd) + 1 + LX;
      if (kind == 1) return enc_r + 1;
      if (kind == 2) return mac_r + 1;
      return imax(cmb_r, mac_r) + 1;
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic go, input logic [1:0] kd, input logic av,
                       input logic [AW-1:0] a, input logic dv, input logic [DW-1:0] d);
      @(negedge clk);
      req_go   = go;
      req_kind = kd;
      addr_vld = av;
      addr     = a;
      data_vld = dv;
      data     = d;
      @(posedge clk);
      #1;
   endtask

   // one request: go at step 0, strobes at given steps, extra address strobe at ad2
   task automatic run(input int kind, input int ad, input int dd, input int ad2,
                      input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output int first, output int pulses);
      first  = -1;
      pulses = 0;
      for (int k = 0; k < RUN; k++) begin
         step(k == 0, 2'(kind),
              (k == ad) || (k == ad2), (k == ad2) ? ~a : a,
              (k == dd), d);
         if (done) begin
            pulses++;
            if (first < 0) first = k;
         end
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int first, pulses, kd;
      logic [DW-1:0] ep, ec, em;

      // R1: reset state
      repeat (3) @(posedge clk);
      #1;
      chk("R1 done in reset", DW'(done), '0);
      chk("R1 results in reset", res_pad | res_cipher | res_mac, '0);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      chk("R1 done after reset", DW'(done), '0);
      chk("R1 results after reset", res_pad | res_cipher | res_mac, '0);

      // table walk: R2 R3 R4 R5 R6 R9
      for (int v = 0; v < NV; v++) begin
         kd = V_KIND[v];
         run(kd, V_AD[v], V_DD[v], -1, V_ADDR[v], V_DATA[v], first, pulses);
         ep = (kd % 2 == 1) ? f_pad(V_ADDR[v]) : '0;
         em = (kd >= 2) ? f_mac(V_DATA[v]) : '0;
         ec = (kd == 3) ? (f_pad(V_ADDR[v]) ^ V_DATA[v]) : '0;
         chk($sformatf("R6 R9 done edge vec%0d", v), DW'(first), DW'(exp_done(kd, V_AD[v], V_DD[v])));
         chk($sformatf("R6 single pulse vec%0d", v), DW'(pulses), 32'd1);
         chk($sformatf("R2 R5 pad vec%0d", v), res_pad, ep);
         chk($sformatf("R3 R5 mac vec%0d", v), res_mac, em);
         chk($sformatf("R4 R5 cipher vec%0d", v), res_cipher, ec);
      end

      // R9: full overlap case finishes before the serial sum
      chk("R9 overlap below serial", DW'(exp_done(3, 0, 0) < (LC + LE + LX + LM)), 32'd1);

      // R7: duplicate address strobe ignored, results held after done
      run(3, 0, 0, 1, 16'h0ABC, 32'hCAFEF00D, first, pulses);
      chk("R7 first address kept pad", res_pad, f_pad(16'h0ABC));
      chk("R7 first address kept cipher", res_cipher, f_pad(16'h0ABC) ^ 32'hCAFEF00D);
      chk("R7 done timing", DW'(first), DW'(exp_done(3, 0, 0)));
      for (int k = 0; k < 5; k++) step(1'b0, 2'b00, 1'b1, 16'h1111, 1'b1, 32'h2222);
      chk("R7 pad held", res_pad, f_pad(16'h0ABC));
      chk("R7 mac held", res_mac, f_mac(32'hCAFEF00D));

      // R8: restart mid-flight
      pulses = 0;
      step(1'b1, 2'b11, 1'b1, 16'h7777, 1'b1, 32'h33333333);
      for (int k = 0; k < 3; k++) begin
         step(1'b0, 2'b11, 1'b0, '0, 1'b0, '0);
         if (done) pulses++;
      end
      chk("R8 no done before restart", DW'(pulses), 32'd0);
      run(2, 0, 0, -1, 16'h0000, 32'h5A5A1234, first, pulses);
      chk("R8 restart done edge", DW'(first), DW'(exp_done(2, 0, 0)));
      chk("R8 restart single pulse", DW'(pulses), 32'd1);
      chk("R8 pad cleared", res_pad, '0);
      chk("R8 cipher cleared", res_cipher, '0);
      chk("R8 new mac", res_mac, f_mac(32'h5A5A1234));

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule